// File: doc/BRIEF.md
# Edge-Kicked Watchdog Timer

This block supervises a processor by watching a single kick line driven from one of its I/O pins. The processor proves it is alive by changing the level of that line, rising or falling, before a programmed number of clock cycles has elapsed. If the line stays still for the whole period, the block pulls an active-low fault output low. That output is normally routed to a non-maskable interrupt so that a recovery routine can run. The fault stays low until the processor kicks again or the system is reset.

The kick line is asynchronous. It passes through a synchronizer, and an edge detector then turns every change of the synchronized level into a one-cycle kick. While the supervisor holds the active-low system reset, the watchdog is idle and its fault output is high. The period starts counting again when reset is released. A combined active-low reset output is also provided. It is low whenever either the system reset or the fault is low, for boards that want one line to reset the processor.

Top module: `wdk_watchdog`

## Requirements
- R1: A low-to-high change and a high-to-low change on `kick_in` are each accepted as a kick.
- R2: A restart edge is the last rising clock edge at which `sys_rst_n` was sampled low, or the edge at which a kick takes effect. If no kick takes effect afterwards, `fault_n` is high through the first PERIOD_CYCLES-1 edges after the restart edge and goes low at edge PERIOD_CYCLES.
- R3: Once low, `fault_n` stays low until a kick takes effect or `sys_rst_n` is sampled low.
- R4: At each edge where `sys_rst_n` is sampled low, `fault_n` goes high and the period restarts. Changes on `kick_in` made while reset is held and settled at least three cycles before release have no effect, so the fault appears exactly PERIOD_CYCLES edges after the last reset edge.
- R5: A level change on `kick_in` takes effect at the third rising edge after the change (two synchronizer stages, then the edge register). At that edge `fault_n` goes high if it was low, and the period restarts from zero.
- R6: A level held for two clock cycles is detected. Both edges of a two-cycle pulse count as kicks, and the second edge is the one that restarts the period.
- R7: `rst_comb_n` is low exactly when `sys_rst_n` is low or `fault_n` is low.
- R8: When a kick takes effect at the same edge at which the fault would be raised (edge PERIOD_CYCLES after a restart), the kick wins and `fault_n` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| sys_rst_n | input | 1 | Active-low system reset from the supervisor, sampled on the clock |
| kick_in | input | 1 | Asynchronous kick line from the processor; any level change is a kick |
| fault_n | output | 1 | Active-low watchdog fault, latched until kick or reset |
| rst_comb_n | output | 1 | Active-low OR of system reset and fault |

## Verification
A period counter that has drifted by even one count moves the fault edge by one cycle. The bench samples `fault_n` on every cycle of each kick gap, so such a drift shows on the next gap that crosses the period boundary. A lost or doubled edge in the synchronizer also shows quickly. Either the fault fails to clear three cycles after a toggle, or the next fault appears at the wrong distance from the second edge of a short pulse. A fault register that forgets its latched value goes high before the next toggle and is caught within one cycle.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10
    } edge_kind_e;

    typedef struct packed {
        logic       kick;
        edge_kind_e kind;
    } kick_evt_t;

    function automatic int unsigned cnt_width(input int unsigned cycles);
        return (cycles < 2) ? 1 : $clog2(cycles);
    endfunction

    function automatic edge_kind_e classify(input logic now_lvl, input logic old_lvl);
        if (now_lvl && !old_lvl) return EDGE_RISE;
        if (!now_lvl && old_lvl) return EDGE_FALL;
        return EDGE_NONE;
    endfunction

endpackage

// File: rtl/wdk_sync_edge.sv
module wdk_sync_edge #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  async_in,
    output wdk_pkg::kick_evt_t    evt
);
    import wdk_pkg::*;

    localparam int unsigned NSTG = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

    logic [NSTG-1:0] stage_q;
    logic            last_q;

    always_ff @(posedge clk) begin
        stage_q[0] <= async_in;
    end

    for (genvar g = 1; g < NSTG; g++) begin : g_stage
        always_ff @(posedge clk) begin
            stage_q[g] <= stage_q[g-1];
        end
    end

    always_ff @(posedge clk) begin
        last_q <= stage_q[NSTG-1];
    end

    always_comb begin
        evt.kind = classify(stage_q[NSTG-1], last_q);
        evt.kick = (evt.kind != EDGE_NONE);
    end

    // R1: after a rise the next detected edge can only be a fall
    p_rise_then_steady_r1: assert property (@(posedge clk) disable iff (rst)
        (evt.kind == EDGE_RISE) |=> (evt.kind != EDGE_RISE));

    p_fall_then_steady_r1: assert property (@(posedge clk) disable iff (rst)
        (evt.kind == EDGE_FALL) |=> (evt.kind != EDGE_FALL));

endmodule

// File: rtl/wdk_period_cnt.sv
module wdk_period_cnt #(
    parameter int unsigned PERIOD_CYCLES = 50000
) (
    input  logic clk,
    input  logic rst,
    input  logic kick,
    output logic fault
);
    localparam int unsigned     CW   = wdk_pkg::cnt_width(PERIOD_CYCLES);
    localparam logic [CW-1:0]   LAST = CW'(PERIOD_CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          fault_q;
    logic          tc;

    assign tc = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            fault_q <= 1'b0;
        end else if (kick) begin
            cnt_q   <= '0;
            fault_q <= 1'b0;
        end else if (tc) begin
            fault_q <= 1'b1;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    assign fault = fault_q;

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    p_fault_at_tc_r2: assert property (@(posedge clk) disable iff (rst)
        (tc && !kick) |=> fault_q);

    p_no_early_fault_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_q) |-> ($past(cnt_q) == LAST));

    p_fault_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (fault_q && !kick) |=> fault_q);

    p_fault_clear_cause_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(fault_q) |-> $past(kick));

    p_kick_restart_r5: assert property (@(posedge clk) disable iff (rst)
        kick |=> (cnt_q == '0 && !fault_q));

    p_tie_kick_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (tc && kick && !fault_q) |=> !fault_q);

endmodule

// File: rtl/wdk_watchdog.sv
module wdk_watchdog #(
    parameter int unsigned PERIOD_CYCLES = 50000,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic sys_rst_n,
    input  logic kick_in,
    output logic fault_n,
    output logic rst_comb_n
);
    logic               rst;
    logic               fault;
    wdk_pkg::kick_evt_t evt;

    assign rst = ~sys_rst_n;

    wdk_sync_edge #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (kick_in),
        .evt      (evt)
    );

    wdk_period_cnt #(
        .PERIOD_CYCLES(PERIOD_CYCLES)
    ) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .kick  (evt.kick),
        .fault (fault)
    );

    assign fault_n    = ~fault;
    assign rst_comb_n = sys_rst_n & ~fault;

    // R4: a reset edge always leaves the fault output high
    p_rst_clears_fault_r4: assert property (@(posedge clk) disable iff (!sys_rst_n)
        $rose(sys_rst_n) |-> fault_n);

endmodule

// File: tb/wdk_watchdog_bench.sv
module wdk_watchdog_bench;

    localparam int CLK_PERIOD = 10;
    localparam int P          = 16;
    localparam int NVEC       = 10;
    localparam int GAPS [NVEC] = '{3, 5, 10, 15, 16, 17, 30, 12, 16, 20};

    logic clk = 1'b0;
    logic sys_rst_n;
    logic kick_in;
    logic fault_n;
    logic rst_comb_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdk_watchdog #(
        .PERIOD_CYCLES(P),
        .SYNC_STAGES  (2)
    ) u_wdk_watchdog (
        .clk        (clk),
        .sys_rst_n  (sys_rst_n),
        .kick_in    (kick_in),
        .fault_n    (fault_n),
        .rst_comb_n (rst_comb_n)
    );

    task automatic check(input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Called at the negedge right after a restart edge; toggles so the
    // next restart happens d edges later (d >= 3).
    task automatic run_gap(input int d);
        for (int j = 1; j <= d - 3; j++) begin
            @(negedge clk);
            check($sformatf("R2 gap %0d cycle %0d", d, j), fault_n, (j >= P) ? 1'b0 : 1'b1);
        end
        kick_in = ~kick_in;
        @(negedge clk);
        check($sformatf("R3 gap %0d pre-kick-2", d), fault_n, (d - 2 >= P) ? 1'b0 : 1'b1);
        @(negedge clk);
        check($sformatf("R8 gap %0d pre-kick-1", d), fault_n, (d - 1 >= P) ? 1'b0 : 1'b1);
        check($sformatf("R7 gap %0d combined", d), rst_comb_n, (d - 1 >= P) ? 1'b0 : 1'b1);
        @(negedge clk);
        check($sformatf("R5 R1 gap %0d restart (level %0b)", d, kick_in), fault_n, 1'b1);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        kick_in   = 1'b0;
        sys_rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R4 reset fault_n", fault_n, 1'b1);
        check("R7 reset combined", rst_comb_n, 1'b0);
        sys_rst_n = 1'b1;

        // table of kick gaps, both edge directions alternate
        for (int i = 0; i < NVEC; i++) begin
            run_gap(GAPS[i]);
        end

        // R3: fault latched over a long quiet stretch
        repeat (P + 5) @(negedge clk);
        check("R3 latched", fault_n, 1'b0);
        check("R7 fault drives combined", rst_comb_n, 1'b0);

        // R4: reset clears fault; kicks during reset ignored
        sys_rst_n = 1'b0;
        @(negedge clk);
        check("R4 reset clears fault", fault_n, 1'b1);
        check("R7 reset drives combined", rst_comb_n, 1'b0);
        kick_in = ~kick_in;
        repeat (5) @(negedge clk);
        sys_rst_n = 1'b1;
        repeat (P - 1) @(negedge clk);
        check("R4 restart high before period", fault_n, 1'b1);
        check("R7 combined idle high", rst_comb_n, 1'b1);
        @(negedge clk);
        check("R4 fault exactly at period", fault_n, 1'b0);

        // R6: two-cycle pulse, both edges counted
        kick_in = ~kick_in;
        repeat (2) @(negedge clk);
        kick_in = ~kick_in;
        @(negedge clk);
        check("R6 first edge clears fault", fault_n, 1'b1);
        repeat (P + 1) @(negedge clk);
        check("R6 second edge restarted period", fault_n, 1'b1);
        @(negedge clk);
        check("R6 fault after second edge", fault_n, 1'b0);

        finish_run();
    end

endmodule